// File: doc/BRIEF.md
# Register-Write to Stream Packetizer

This block turns a host's register writes into beats of a valid/ready byte stream on the transmit side. For each packet the host first writes the packet length. Then, for each beat, it may write a metadata word that sets the byte strobe, the end-of-packet flag and the source and destination port masks. A write to the data register then commits one beat. The block builds the beat from the written word and the pending metadata, and stores it in a packet buffer. The buffer drains to a stream master port.

The stream word is the written word with its byte order reversed: the most significant byte of the register write leaves on byte lane 0. Each beat carries a user field that packs the current packet length with the two port masks. A status register reports the buffer level, a full bit and a sticky overflow bit. Reading the status register clears the overflow bit. Data writes that arrive while the buffer is full are discarded.

Top module: `regwr_stream_pkz`

## Requirements
- R1: Writes decode on the offset: 0x00 commits a data beat, 0x08 sets the pending metadata and 0x10 sets the packet length. Only a write to 0x00 adds a beat to the stream.
- R2: A length write stores bits 15:0, which appear in tuser[15:0] of every later beat. The same write discards any pending metadata.
- R3: Metadata fields are the strobe in bits DATA_W/8-1:0, the last flag in bit 15, the source mask in bits 23:16 and the destination mask in bits 31:24. They reach the beat as tkeep, tlast, tuser[23:16] and tuser[31:24].
- R4: Each data write uses up the pending metadata. A data write with no pending metadata produces tkeep all ones, tlast 0, source mask 0x02 and destination mask 0x00.
- R5: tdata byte lane k (bits 8k+7:8k) equals written byte DATA_W/8-1-k.
- R6: A beat without the last flag has tkeep all ones. On a last beat, tkeep covers lane 0 up to the highest strobe lane that is set, and lane 0 is always included.
- R7: The buffer holds BUF_BYTES/(DATA_W/8) beats and delivers them in write order.
- R8: A data write while the buffer is full is dropped and never appears on the stream. Status bit 0 reads 1 while the buffer is full.
- R9: Status bit 1 is set by a dropped write and stays set until a status read. That read returns the bit as 1, and the next read returns 0.
- R10: Status bits 16 and up give the number of stored beats. The status register is at offset 0x18, and reads at any other offset return 0.
- R11: While tvalid is high and tready is low, tvalid, tdata, tkeep, tlast and tuser stay unchanged. One beat leaves on each cycle in which both are high.
- R12: After reset, tvalid is 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read word (status) |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Stream data, byte-reversed |
| m_tkeep | output | DATA_W/8 | Stream byte enables |
| m_tlast | output | 1 | End of packet |
| m_tuser | output | 32 | {destination mask, source mask, length} |

## Verification
The bench builds the block with DATA_W=64, so the eight-lane byte reversal and the strobe filling with holes get full coverage. It sets BUF_BYTES=64, which shrinks the buffer to eight beats. That makes the full state, a dropped write, the clear-on-read overflow bit and a held beat under back-pressure reachable in a few dozen cycles.

// File: rtl/pkz_pkg.sv
package pkz_pkg;
  localparam int OFS_DATA  = 'h00;
  localparam int OFS_META  = 'h08;
  localparam int OFS_LEN   = 'h10;
  localparam int OFS_STAT  = 'h18;

  localparam int LEN_W         = 16;
  localparam int PORT_W        = 8;
  localparam int USER_W        = LEN_W + 2 * PORT_W;
  localparam int META_LAST_BIT = 15;
  localparam int META_SRC_LSB  = 16;
  localparam int META_DST_LSB  = 24;

  localparam logic [PORT_W-1:0] SRC_HOST_DEFAULT = 8'h02;
  localparam logic [PORT_W-1:0] DST_DEFAULT      = 8'h00;

  localparam int ST_FULL_BIT = 0;
  localparam int ST_OVF_BIT  = 1;
  localparam int ST_LVL_LSB  = 16;
  localparam int ST_W        = 32;
endpackage

// File: rtl/pkz_beat_asm.sv
module pkz_beat_asm
  import pkz_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                beat_commit,
  output logic [DATA_W-1:0]   beat_data,
  output logic [DATA_W/8-1:0] beat_keep,
  output logic                beat_last,
  output logic [USER_W-1:0]   beat_user
);
  localparam int KEEP_W = DATA_W / 8;

  function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < KEEP_W; i++) r[8*i +: 8] = w[DATA_W-8-8*i +: 8];
    return r;
  endfunction

  function automatic logic [KEEP_W-1:0] shape_keep(input logic [KEEP_W-1:0] s,
                                                   input logic last);
    logic [KEEP_W-1:0] k;
    for (int i = 0; i < KEEP_W; i++) k[i] = |(s >> i);
    k[0] = 1'b1;
    return last ? k : '1;
  endfunction

  logic sel_data, sel_meta, sel_len;
  assign sel_data = wr_en && (wr_addr == ADDR_W'(OFS_DATA));
  assign sel_meta = wr_en && (wr_addr == ADDR_W'(OFS_META));
  assign sel_len  = wr_en && (wr_addr == ADDR_W'(OFS_LEN));

  logic [LEN_W-1:0]  len_q;
  logic              meta_vld_q;
  logic [KEEP_W-1:0] strb_q;
  logic              last_q;
  logic [PORT_W-1:0] src_q, dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q      <= '0;
      meta_vld_q <= 1'b0;
      strb_q     <= '0;
      last_q     <= 1'b0;
      src_q      <= '0;
      dst_q      <= '0;
    end else if (sel_len) begin
      len_q      <= wr_data[LEN_W-1:0];
      meta_vld_q <= 1'b0;
    end else if (sel_meta) begin
      meta_vld_q <= 1'b1;
      strb_q     <= wr_data[KEEP_W-1:0];
      last_q     <= wr_data[META_LAST_BIT];
      src_q      <= wr_data[META_SRC_LSB +: PORT_W];
      dst_q      <= wr_data[META_DST_LSB +: PORT_W];
    end else if (sel_data) begin
      meta_vld_q <= 1'b0;
    end
  end

  logic              eff_last;
  logic [KEEP_W-1:0] eff_strb;
  logic [PORT_W-1:0] eff_src, eff_dst;
  assign eff_last = meta_vld_q && last_q;
  assign eff_strb = meta_vld_q ? strb_q : '1;
  assign eff_src  = meta_vld_q ? src_q : SRC_HOST_DEFAULT;
  assign eff_dst  = meta_vld_q ? dst_q : DST_DEFAULT;

  assign beat_commit = sel_data;
  assign beat_data   = swap_lanes(wr_data);
  assign beat_keep   = shape_keep(eff_strb, eff_last);
  assign beat_last   = eff_last;
  assign beat_user   = {eff_dst, eff_src, len_q};

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  // R6: every committed beat enables at least byte lane 0
  assert_lane0_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_commit |-> beat_keep[0]);
endmodule

// File: rtl/pkz_fifo.sv
module pkz_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: level never exceeds the buffer depth
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R10: a lone accepted push raises the level by one
  assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: rtl/pkz_status.sv
module pkz_status
  import pkz_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_commit,
  input  logic              full,
  input  logic [CNT_W-1:0]  count,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ST_W-1:0]   rd_data,
  output logic              ovf_flag
);
  logic drop, stat_rd;
  assign drop    = beat_commit && full;
  assign stat_rd = rd_en && (rd_addr == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (drop)    ovf_flag <= 1'b1;
    else if (stat_rd) ovf_flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (stat_rd) begin
      rd_data[ST_FULL_BIT]           = full;
      rd_data[ST_OVF_BIT]            = ovf_flag;
      rd_data[ST_LVL_LSB +: CNT_W]   = count;
    end
  end

  // R9: a dropped write leaves the sticky flag set
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag);
  // R9: the flag only rises after a drop
  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(drop));
endmodule

// File: rtl/regwr_stream_pkz.sv
module regwr_stream_pkz
  import pkz_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic                m_tlast,
  output logic [31:0]         m_tuser
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int DEPTH  = BUF_BYTES / KEEP_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ENT_W  = USER_W + 1 + KEEP_W + DATA_W;

  logic              beat_commit, beat_last;
  logic [DATA_W-1:0] beat_data;
  logic [KEEP_W-1:0] beat_keep;
  logic [USER_W-1:0] beat_user;

  pkz_beat_asm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_asm (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .beat_commit, .beat_data, .beat_keep, .beat_last, .beat_user
  );

  logic             buf_full, buf_empty, buf_push, buf_pop;
  logic [CNT_W-1:0] buf_count;
  logic [ENT_W-1:0] buf_dout;

  assign buf_push = beat_commit && !buf_full;
  assign buf_pop  = m_tvalid && m_tready;

  pkz_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_buf (
    .clk, .rst_n,
    .push (buf_push),
    .din  ({beat_user, beat_last, beat_keep, beat_data}),
    .pop  (buf_pop),
    .dout (buf_dout),
    .full (buf_full),
    .empty(buf_empty),
    .count(buf_count)
  );

  assign m_tvalid = !buf_empty;
  assign {m_tuser, m_tlast, m_tkeep, m_tdata} = buf_dout;

  logic ovf_flag;
  pkz_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stat (
    .clk, .rst_n, .beat_commit,
    .full (buf_full),
    .count(buf_count),
    .rd_en, .rd_addr, .rd_data, .ovf_flag
  );

  // R11: a stalled beat holds every field
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                 && $stable(m_tlast) && $stable(m_tuser)));
  // R6: delivered enables are contiguous from lane 0
  assert_keep_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep[0] && (((m_tkeep + KEEP_W'(1)) & m_tkeep) == '0)));
  // R6: only a last beat may be partial
  assert_full_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (&m_tkeep));
  // R8: a write into a full buffer leaves the level unchanged or lowered
  assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_commit && buf_full) |=> buf_count <= $past(buf_count));
endmodule

// File: tb/test_regwr_stream_pkz.sv
module test_regwr_stream_pkz;
  localparam int DW = 64;
  localparam int AW = 8;
  localparam int KW = DW / 8;
  localparam logic [AW-1:0] A_DATA = 8'h00, A_META = 8'h08, A_LEN = 8'h10, A_STAT = 8'h18;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, m_tready = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [31:0]   rd_data, m_tuser;
  logic          m_tvalid, m_tlast;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  regwr_stream_pkz #(.DATA_W(DW), .ADDR_W(AW), .BUF_BYTES(64)) i_regwr_stream_pkz (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data,
    .m_tvalid, .m_tready, .m_tdata, .m_tkeep, .m_tlast, .m_tuser
  );

  // Vector table (R3, R4, R5, R6): optional metadata, data word, expected beat
  localparam int NV = 6;
  localparam bit          V_HASM [NV] = '{0, 1, 1, 1, 0, 1};
  localparam logic [63:0] V_META [NV] = '{64'h0, 64'h1002_00FF, 64'h0102_00FF,
                                          64'h0102_000F, 64'h0, 64'h0102_8003};
  localparam logic [63:0] V_DATA [NV] = '{64'h0102030405060708, 64'h1122334455667788,
                                          64'hA0A1A2A3A4A5A6A7, 64'hDEADBEEFCAFEF00D,
                                          64'h0000000000000001, 64'hFFEE000000000000};
  localparam logic [63:0] V_XDAT [NV] = '{64'h0807060504030201, 64'h8877665544332211,
                                          64'hA7A6A5A4A3A2A1A0, 64'h0DF0FECAEFBEADDE,
                                          64'h0100000000000000, 64'h000000000000EEFF};
  localparam logic [7:0]  V_XKEEP[NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h03};
  localparam bit          V_XLAST[NV] = '{0, 0, 0, 0, 0, 1};
  localparam logic [31:0] V_XUSER[NV] = '{32'h0002_002A, 32'h1002_002A, 32'h0102_002A,
                                          32'h0102_002A, 32'h0002_002A, 32'h0102_002A};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_stat(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pop();
    m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  function automatic logic [63:0] rev(input logic [63:0] w);
    return {<<8{w}};
  endfunction

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 tvalid", 64'(m_tvalid), 64'h0);
    rd_stat(A_STAT, st);
    chk("R12 status", 64'(st), 64'h0);
    rd_stat(A_META, st);
    chk("R10 non-status read", 64'(st), 64'h0);

    // Table walk
    wr(A_LEN, 64'd42);
    for (int i = 0; i < NV; i++) begin
      if (V_HASM[i]) begin
        wr(A_META, V_META[i]);
        chk("R1 meta alone no beat", 64'(m_tvalid), 64'h0);
      end
      wr(A_DATA, V_DATA[i]);
      chk("R1 beat present", 64'(m_tvalid), 64'h1);
      chk("R5 tdata", m_tdata, V_XDAT[i]);
      chk("R5 tdata reverse", m_tdata, rev(V_DATA[i]));
      chk("R6 tkeep", 64'(m_tkeep), 64'(V_XKEEP[i]));
      chk("R3 tlast", 64'(m_tlast), 64'(V_XLAST[i]));
      chk("R3 tuser", 64'(m_tuser), 64'(V_XUSER[i]));
      pop();
    end
    chk("R11 drained", 64'(m_tvalid), 64'h0);

    // R6 strobe with a hole and an empty strobe on last beats
    wr(A_LEN, 64'd5);
    wr(A_META, 64'h0202_8005);
    wr(A_DATA, 64'h1);
    wr(A_META, 64'h0202_8000);
    wr(A_DATA, 64'h2);
    chk("R6 hole filled", 64'(m_tkeep), 64'h07);
    chk("R6 hole last", 64'(m_tlast), 64'h1);
    pop();
    chk("R6 empty strobe keeps lane0", 64'(m_tkeep), 64'h01);
    pop();

    // R2 length write discards pending metadata, R4 defaults apply
    wr(A_META, 64'h0408_8003);
    chk("R1 meta no beat", 64'(m_tvalid), 64'h0);
    wr(A_LEN, 64'd7);
    wr(A_DATA, 64'h5);
    chk("R2 keep default", 64'(m_tkeep), 64'hFF);
    chk("R2 last default", 64'(m_tlast), 64'h0);
    chk("R2 user", 64'(m_tuser), 64'h0002_0007);
    pop();

    // R7 R8 R9 R10 fill, overflow, clear-on-read, hold, order
    wr(A_LEN, 64'd64);
    for (int i = 0; i < 8; i++) wr(A_DATA, 64'(i + 1));
    rd_stat(A_STAT, st);
    chk("R10 level full", 64'(st), 64'h0008_0001);
    wr(A_DATA, 64'd99);
    rd_stat(A_STAT, st);
    chk("R9 overflow set", 64'(st), 64'h0008_0003);
    rd_stat(A_STAT, st);
    chk("R9 overflow cleared", 64'(st), 64'h0008_0001);
    held = m_tdata;
    repeat (3) @(negedge clk);
    chk("R11 held tdata", m_tdata, held);
    chk("R11 held tvalid", 64'(m_tvalid), 64'h1);
    for (int i = 0; i < 8; i++) begin
      chk("R7 order", m_tdata, rev(64'(i + 1)));
      pop();
    end
    chk("R8 dropped beat absent", 64'(m_tvalid), 64'h0);
    rd_stat(A_STAT, st);
    chk("R10 level empty", 64'(st), 64'h0);

    // R11 back-to-back drain with tready held high
    wr(A_DATA, 64'hA);
    wr(A_DATA, 64'hB);
    @(negedge clk);
    m_tready = 1'b1;
    @(negedge clk);
    chk("R11 second beat next cycle", m_tdata, rev(64'hB));
    @(negedge clk);
    m_tready = 1'b0;
    chk("R11 both gone", 64'(m_tvalid), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule